// File: doc/BRIEF.md
# SMBus Host Command Engine

This block is the byte-wide register front end of an SMBus host controller. Software programs a target address with its direction bit, a command byte, and up to two data bytes. It then writes the control register with the start bit set and a protocol code. The engine checks the request and, if the request is legal, presents it for one cycle on an abstract transaction port. It then waits for a completion on that port. A completion either carries read data back into the data registers or reports an error.

A status register collects the outcome. It holds a live busy flag and a set of sticky event flags, and software clears the event flags by writing ones to them. An interrupt output combines the event flags with an enable bit held in the control register. A kill bit in the control register abandons the operation in progress. A small buffer index, shared with a neighbouring block-buffer block, advances on each write to the block data register. Bit-level wire timing and packet error checking are handled outside this block.

Top module: `smbus_host_cmd`

## Requirements
- R1: After reset the status register reads 0x00, `irq` is low, `req_valid` is low and `buf_idx` is 0.
- R2: A write to the status register (offset 0x00) clears each event flag (bits 7..1) written as 1. It can never clear busy (bit 0), which stays 1 for the whole time a request is outstanding.
- R3: The control register is at offset 0x02. Its bit 6 is start and is never stored. A control read returns the stored bits 4..0 with bits 7..5 as zero.
- R4: A start (control bit 6) with a legal protocol code (control bits 4..2, values 0..6) raises `req_valid` for exactly one cycle, in the cycle after the write. The request carries the target address (address register bits 7..1), the direction (bit 0, 1 = read), the command, `{data1,data0}` and the protocol code. Busy is set from the write until the completion.
- R5: A successful completion clears busy and sets done (status bit 1). A read completion loads data0 from response bits 7..0 for byte (1), byte-data (2), block (5) and I2C block read (6). For word-data (3) it also loads data1 from bits 15..8. Process call (4) loads both bytes in either direction. Write completions leave data0 and data1 unchanged.
- R6: An error completion clears busy, sets device error (status bit 2) and leaves the data registers unchanged.
- R7: A start with protocol code 7 sets device error and issues no request.
- R8: A start with protocol code 6 and write direction sets device error and issues no request.
- R9: A start while device error is already set issues no request, and device error stays set.
- R10: A control write with bit 1 set ends the operation. It sets failed (status bit 4), clears busy and returns `buf_idx` to 0. A completion arriving afterwards has no effect.
- R11: `irq` is high exactly when control bit 0 is set and any of status bits 7..1 is set.
- R12: Each write to block data (offset 0x07) stores the byte, which reads back at the same offset, and advances `buf_idx` by one, wrapping from BUF_DEPTH-1 to 0.
- R13: Auxiliary control (offset 0x0D) keeps only bits 1..0 of a write and reads back with bits 7..2 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| waddr | input | 6 | Write offset |
| wdata | input | 8 | Write data |
| raddr | input | 6 | Read offset |
| rdata | output | 8 | Read data for `raddr` |
| irq | output | 1 | Interrupt request |
| req_valid | output | 1 | One-cycle transaction request |
| req_taddr | output | 7 | Target address |
| req_rd | output | 1 | Direction, 1 = read |
| req_cmd | output | 8 | Command byte |
| req_wdata | output | 16 | Write data, high byte data1 |
| req_proto | output | 3 | Protocol code |
| rsp_valid | input | 1 | Completion strobe |
| rsp_err | input | 1 | Completion is an error |
| rsp_rdata | input | 16 | Read data of the completion |
| buf_idx | output | IDX_W | Block buffer index |

## Verification
Legal requests are driven with word writes, word reads and byte reads. This separates which data bytes a completion loads by protocol and direction, and shows that write completions leave the data registers alone. Error replies, reserved codes, a write-direction I2C block read and starts made while device error is set confirm that no request reaches the port and only device error rises. A kill issued while a request is outstanding, followed by a late reply, shows that the reply is ignored. Block data writes run past the buffer depth to check that the index wraps.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] OFS_STAT  = 6'h00;
  localparam logic [REG_AW-1:0] OFS_CTL   = 6'h02;
  localparam logic [REG_AW-1:0] OFS_CMD   = 6'h03;
  localparam logic [REG_AW-1:0] OFS_TADDR = 6'h04;
  localparam logic [REG_AW-1:0] OFS_D0    = 6'h05;
  localparam logic [REG_AW-1:0] OFS_D1    = 6'h06;
  localparam logic [REG_AW-1:0] OFS_BLK   = 6'h07;
  localparam logic [REG_AW-1:0] OFS_AUX   = 6'h0D;

  // status bit positions
  localparam int SB_BUSY   = 0;
  localparam int SB_DONE   = 1;
  localparam int SB_DEVERR = 2;
  localparam int SB_FAILED = 4;

  // control bit positions
  localparam int CB_IE    = 0;
  localparam int CB_KILL  = 1;
  localparam int CB_START = 6;

  typedef enum logic [2:0] {
    PR_QUICK     = 3'd0,
    PR_BYTE      = 3'd1,
    PR_BYTE_DATA = 3'd2,
    PR_WORD      = 3'd3,
    PR_PCALL     = 3'd4,
    PR_BLOCK     = 3'd5,
    PR_I2C_BRD   = 3'd6,
    PR_RSVD      = 3'd7
  } proto_e;

  typedef enum logic [1:0] {
    EN_IDLE  = 2'd0,
    EN_ISSUE = 2'd1,
    EN_WAIT  = 2'd2
  } eng_st_e;
endpackage

// File: rtl/smbh_engine.sv
module smbh_engine
  import smbh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_req,
  input  logic        kill_req,
  input  logic [2:0]  proto_i,
  input  logic        dir_rd,
  input  logic        dev_err_now,
  input  logic        rsp_valid,
  input  logic        rsp_err,
  input  logic [15:0] rsp_data,
  output logic        req_valid,
  output logic [2:0]  req_proto,
  output logic        req_rd,
  output logic        busy,
  output logic        evt_done,
  output logic        evt_dev_err,
  output logic        evt_failed,
  output logic        ld_lo,
  output logic        ld_hi,
  output logic [15:0] ld_val
);
  eng_st_e st_q, st_d;
  proto_e  proto_q, proto_d;
  logic    rd_q, rd_d;
  logic    reject;

  assign reject = dev_err_now || (proto_i == PR_RSVD) ||
                  ((proto_i == PR_I2C_BRD) && !dir_rd);

  always_comb begin
    st_d        = st_q;
    proto_d     = proto_q;
    rd_d        = rd_q;
    evt_done    = 1'b0;
    evt_dev_err = 1'b0;
    evt_failed  = 1'b0;
    ld_lo       = 1'b0;
    ld_hi       = 1'b0;
    if (kill_req) begin
      st_d       = EN_IDLE;
      evt_failed = 1'b1;
    end else begin
      case (st_q)
        EN_IDLE: begin
          if (start_req) begin
            if (reject) begin
              evt_dev_err = 1'b1;
            end else begin
              st_d    = EN_ISSUE;
              proto_d = proto_e'(proto_i);
              rd_d    = dir_rd;
            end
          end
        end
        EN_ISSUE: st_d = EN_WAIT;
        EN_WAIT: begin
          if (rsp_valid) begin
            st_d = EN_IDLE;
            if (rsp_err) begin
              evt_dev_err = 1'b1;
            end else begin
              evt_done = 1'b1;
              case (proto_q)
                PR_BYTE, PR_BYTE_DATA, PR_BLOCK, PR_I2C_BRD: ld_lo = rd_q;
                PR_WORD: begin
                  ld_lo = rd_q;
                  ld_hi = rd_q;
                end
                PR_PCALL: begin
                  ld_lo = 1'b1;
                  ld_hi = 1'b1;
                end
                default: ;
              endcase
            end
          end
        end
        default: st_d = EN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= EN_IDLE;
      proto_q <= PR_QUICK;
      rd_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      proto_q <= proto_d;
      rd_q    <= rd_d;
    end
  end

  assign req_valid = (st_q == EN_ISSUE);
  assign busy      = (st_q != EN_IDLE);
  assign req_proto = proto_q;
  assign req_rd    = rd_q;
  assign ld_val    = rsp_data;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R4
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy); // R4
  AST_KILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    kill_req |=> !busy); // R10
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && dev_err_now) |=> !req_valid); // R9
endmodule

// File: rtl/smbh_status.sv
module smbh_status
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stat,
  input  logic [7:1] wbits,
  input  logic       busy,
  input  logic       ie,
  input  logic       evt_done,
  input  logic       evt_dev_err,
  input  logic       evt_failed,
  output logic [7:0] stat,
  output logic       irq
);
  logic [7:1] flags_q, flags_d, set_v, clr_v;
  logic       flags_en;

  always_comb begin
    set_v            = '0;
    set_v[SB_DONE]   = evt_done;
    set_v[SB_DEVERR] = evt_dev_err;
    set_v[SB_FAILED] = evt_failed;
    clr_v            = wr_stat ? wbits : '0;
    flags_d          = (flags_q & ~clr_v) | set_v;
    flags_en         = wr_stat | evt_done | evt_dev_err | evt_failed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign stat = {flags_q, busy};
  assign irq  = ie & (|flags_q);

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> stat[SB_DONE]); // R5
  AST_FAILED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_failed |=> stat[SB_FAILED]); // R10
  AST_DEVERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[SB_DEVERR] && !wr_stat) |=> stat[SB_DEVERR]); // R6
endmodule

// File: rtl/smbh_regs.sv
module smbh_regs
  import smbh_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              kill_req,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [15:0]       ld_val,
  output logic [4:0]        ctl_q,
  output logic [7:0]        cmd_q,
  output logic [7:0]        taddr_q,
  output logic [7:0]        d0_q,
  output logic [7:0]        d1_q,
  output logic [7:0]        blk_q,
  output logic [1:0]        aux_q,
  output logic [IDX_W-1:0]  buf_idx
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BUF_DEPTH - 1);

  logic wr_ctl, wr_cmd, wr_ta, wr_d0, wr_d1, wr_blk, wr_aux;
  logic en_d0, en_d1, en_idx;
  logic [7:0]       d0_d, d1_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    wr_ctl = wr_en && (waddr == OFS_CTL);
    wr_cmd = wr_en && (waddr == OFS_CMD);
    wr_ta  = wr_en && (waddr == OFS_TADDR);
    wr_d0  = wr_en && (waddr == OFS_D0);
    wr_d1  = wr_en && (waddr == OFS_D1);
    wr_blk = wr_en && (waddr == OFS_BLK);
    wr_aux = wr_en && (waddr == OFS_AUX);
    en_d0  = wr_d0 | ld_lo;
    en_d1  = wr_d1 | ld_hi;
    d0_d   = ld_lo ? ld_val[7:0]  : wdata;
    d1_d   = ld_hi ? ld_val[15:8] : wdata;
    en_idx = kill_req | wr_blk;
    if (kill_req)               idx_d = '0;
    else if (buf_idx == IDX_LAST) idx_d = '0;
    else                        idx_d = buf_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      cmd_q   <= '0;
      taddr_q <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      blk_q   <= '0;
      aux_q   <= '0;
      buf_idx <= '0;
    end else begin
      if (wr_ctl) ctl_q   <= wdata[4:0];
      if (wr_cmd) cmd_q   <= wdata;
      if (wr_ta)  taddr_q <= wdata;
      if (en_d0)  d0_q    <= d0_d;
      if (en_d1)  d1_q    <= d1_d;
      if (wr_blk) blk_q   <= wdata;
      if (wr_aux) aux_q   <= wdata[1:0];
      if (en_idx) buf_idx <= idx_d;
    end
  end

  AST_IDX_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    kill_req |=> (buf_idx == '0)); // R10
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_blk && !kill_req) |=> $stable(buf_idx)); // R12
endmodule

// File: rtl/smbus_host_cmd.sv
module smbus_host_cmd
  import smbh_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [REG_AW-1:0] raddr,
  output logic [7:0]        rdata,
  output logic              irq,
  output logic              req_valid,
  output logic [6:0]        req_taddr,
  output logic              req_rd,
  output logic [7:0]        req_cmd,
  output logic [15:0]       req_wdata,
  output logic [2:0]        req_proto,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [15:0]       rsp_rdata,
  output logic [IDX_W-1:0]  buf_idx
);
  logic        wr_ctl, wr_stat, start_req, kill_req;
  logic        busy, evt_done, evt_dev_err, evt_failed;
  logic        ld_lo, ld_hi;
  logic [15:0] ld_val;
  logic [4:0]  ctl_q;
  logic [7:0]  cmd_q, taddr_q, d0_q, d1_q, blk_q, stat;
  logic [1:0]  aux_q;

  assign wr_ctl    = wr_en && (waddr == OFS_CTL);
  assign wr_stat   = wr_en && (waddr == OFS_STAT);
  assign start_req = wr_ctl && wdata[CB_START];
  assign kill_req  = wr_ctl && wdata[CB_KILL];

  smbh_engine u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .kill_req    (kill_req),
    .proto_i     (wdata[4:2]),
    .dir_rd      (taddr_q[0]),
    .dev_err_now (stat[SB_DEVERR]),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_data    (rsp_rdata),
    .req_valid   (req_valid),
    .req_proto   (req_proto),
    .req_rd      (req_rd),
    .busy        (busy),
    .evt_done    (evt_done),
    .evt_dev_err (evt_dev_err),
    .evt_failed  (evt_failed),
    .ld_lo       (ld_lo),
    .ld_hi       (ld_hi),
    .ld_val      (ld_val)
  );

  smbh_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stat     (wr_stat),
    .wbits       (wdata[7:1]),
    .busy        (busy),
    .ie          (ctl_q[CB_IE]),
    .evt_done    (evt_done),
    .evt_dev_err (evt_dev_err),
    .evt_failed  (evt_failed),
    .stat        (stat),
    .irq         (irq)
  );

  smbh_regs #(.BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .waddr    (waddr),
    .wdata    (wdata),
    .kill_req (kill_req),
    .ld_lo    (ld_lo),
    .ld_hi    (ld_hi),
    .ld_val   (ld_val),
    .ctl_q    (ctl_q),
    .cmd_q    (cmd_q),
    .taddr_q  (taddr_q),
    .d0_q     (d0_q),
    .d1_q     (d1_q),
    .blk_q    (blk_q),
    .aux_q    (aux_q),
    .buf_idx  (buf_idx)
  );

  assign req_taddr = taddr_q[7:1];
  assign req_cmd   = cmd_q;
  assign req_wdata = {d1_q, d0_q};

  always_comb begin
    case (raddr)
      OFS_STAT:  rdata = stat;
      OFS_CTL:   rdata = {3'b000, ctl_q};
      OFS_CMD:   rdata = cmd_q;
      OFS_TADDR: rdata = taddr_q;
      OFS_D0:    rdata = d0_q;
      OFS_D1:    rdata = d1_q;
      OFS_BLK:   rdata = blk_q;
      OFS_AUX:   rdata = {6'd0, aux_q};
      default:   rdata = 8'h00;
    endcase
  end

  AST_BUSY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stat && !kill_req && !rsp_valid) |=> stat[SB_BUSY]); // R2
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[CB_IE] |-> !irq); // R11
endmodule

// File: tb/tb_smbus_host_cmd.sv
module tb_smbus_host_cmd;
  localparam int CLK_P = 10;
  localparam int DEPTH = 32;
  localparam int IW    = $clog2(DEPTH);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  waddr = '0;
  logic [7:0]  wdata = '0;
  logic [5:0]  raddr = '0;
  logic [7:0]  rdata;
  logic        irq, req_valid, req_rd;
  logic [6:0]  req_taddr;
  logic [7:0]  req_cmd;
  logic [15:0] req_wdata;
  logic [2:0]  req_proto;
  logic        rsp_valid = 1'b0;
  logic        rsp_err = 1'b0;
  logic [15:0] rsp_rdata = '0;
  logic [IW-1:0] buf_idx;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct packed {
    logic [6:0]  ta;
    logic        rd;
    logic [7:0]  cmd;
    logic [15:0] wd;
    logic [2:0]  pr;
  } req_t;
  req_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  smbus_host_cmd #(.BUF_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata), .irq(irq), .req_valid(req_valid),
    .req_taddr(req_taddr), .req_rd(req_rd), .req_cmd(req_cmd),
    .req_wdata(req_wdata), .req_proto(req_proto), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .buf_idx(buf_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: every request seen on the port must match the scoreboard head
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4/R7/R8/R9 unexpected request", int'(req_proto), 0);
      end else begin
        req_t e, a;
        e = exp_q.pop_front();
        a = '{req_taddr, req_rd, req_cmd, req_wdata, req_proto};
        chk(a == e, "R4 request fields", int'(a), int'(e));
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [7:0] e, input string tag);
    raddr = a;
    #1;
    chk(rdata === e, tag, int'(rdata), int'(e));
  endtask

  task automatic respond(input logic err, input logic [15:0] d);
    repeat (2) @(negedge clk);
    rsp_valid = 1'b1; rsp_err = err; rsp_rdata = d;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_err = 1'b0;
  endtask

  task automatic start(input logic [7:0] ctl, input bit expect_req);
    if (expect_req) begin
      exp_q.push_back('{dut_ta(), dut_rd(), dut_cmd(), dut_wd(), ctl[4:2]});
    end
    wr(6'h02, ctl);
  endtask

  // shadow of programmed fields, kept by the bench
  logic [7:0] sh_ta, sh_cmd, sh_d0, sh_d1;
  function automatic logic [6:0]  dut_ta();  return sh_ta[7:1]; endfunction
  function automatic logic        dut_rd();  return sh_ta[0];   endfunction
  function automatic logic [7:0]  dut_cmd(); return sh_cmd;     endfunction
  function automatic logic [15:0] dut_wd();  return {sh_d1, sh_d0}; endfunction

  task automatic prog(input logic [7:0] ta, input logic [7:0] cm,
                      input logic [7:0] d0, input logic [7:0] d1);
    sh_ta = ta; sh_cmd = cm; sh_d0 = d0; sh_d1 = d1;
    wr(6'h04, ta); wr(6'h03, cm); wr(6'h05, d0); wr(6'h06, d1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk(6'h00, 8'h00, "R1 status after reset");
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(buf_idx == '0, "R1 buf_idx", int'(buf_idx), 0);
    chk(req_valid == 1'b0, "R1 req_valid", req_valid, 0);

    // R13 aux control
    wr(6'h0D, 8'hFF);
    rd_chk(6'h0D, 8'h03, "R13 aux readback");

    // word write, interrupts enabled
    prog(8'hA0, 8'h12, 8'h34, 8'h56);
    start(8'h4D, 1);
    rd_chk(6'h00, 8'h01, "R4 busy after start");
    rd_chk(6'h02, 8'h0D, "R3 control readback without start");
    wr(6'h00, 8'hFF);
    rd_chk(6'h00, 8'h01, "R2 busy not cleared by write");
    respond(1'b0, 16'hFFFF);
    rd_chk(6'h00, 8'h02, "R5 done after write completion");
    chk(irq == 1'b1, "R11 irq with enable and done", irq, 1);
    rd_chk(6'h05, 8'h34, "R5 data0 kept on write");
    wr(6'h00, 8'hFF);
    rd_chk(6'h00, 8'h00, "R2 flags cleared");
    chk(irq == 1'b0, "R11 irq low after clear", irq, 0);

    // word read, interrupts disabled
    prog(8'hA1, 8'h12, 8'h34, 8'h56);
    start(8'h4C, 1);
    respond(1'b0, 16'hBEEF);
    rd_chk(6'h05, 8'hEF, "R5 word read low");
    rd_chk(6'h06, 8'hBE, "R5 word read high");
    rd_chk(6'h00, 8'h02, "R5 done word read");
    chk(irq == 1'b0, "R11 irq masked", irq, 0);
    wr(6'h00, 8'h02);

    // byte read
    sh_d0 = 8'hEF; sh_d1 = 8'hBE;
    start(8'h44, 1);
    respond(1'b0, 16'h1177);
    rd_chk(6'h05, 8'h77, "R5 byte read data0");
    rd_chk(6'h06, 8'hBE, "R5 byte read keeps data1");
    wr(6'h00, 8'h02);

    // error completion then start while device error set
    sh_d0 = 8'h77;
    start(8'h48, 1);
    respond(1'b1, 16'h5555);
    rd_chk(6'h00, 8'h04, "R6 device error, busy clear");
    rd_chk(6'h05, 8'h77, "R6 data0 unchanged");
    start(8'h48, 0);
    repeat (3) @(negedge clk);
    rd_chk(6'h00, 8'h04, "R9 no launch with device error");
    wr(6'h00, 8'h04);

    // reserved protocol code
    start(8'h5C, 0);
    repeat (3) @(negedge clk);
    rd_chk(6'h00, 8'h04, "R7 reserved code rejected");
    wr(6'h00, 8'h04);

    // I2C block read: write direction rejected, read direction issued
    prog(8'hA0, 8'h21, 8'h04, 8'h00);
    start(8'h58, 0);
    repeat (3) @(negedge clk);
    rd_chk(6'h00, 8'h04, "R8 block read with write dir rejected");
    wr(6'h00, 8'h04);
    prog(8'hA1, 8'h21, 8'h04, 8'h00);
    start(8'h58, 1);
    respond(1'b0, 16'h0010);
    rd_chk(6'h05, 8'h10, "R5 I2C block read count");
    wr(6'h00, 8'h02);

    // kill with request outstanding
    prog(8'hA0, 8'h00, 8'h00, 8'h00);
    start(8'h40, 1);
    wr(6'h07, 8'h11); wr(6'h07, 8'h22); wr(6'h07, 8'h33);
    chk(buf_idx == IW'(3), "R12 index after 3 writes", int'(buf_idx), 3);
    rd_chk(6'h07, 8'h33, "R12 block data readback");
    wr(6'h02, 8'h02);
    rd_chk(6'h00, 8'h10, "R10 failed set, busy clear");
    chk(buf_idx == '0, "R10 index reset", int'(buf_idx), 0);
    respond(1'b0, 16'hABCD);
    rd_chk(6'h00, 8'h10, "R10 late completion ignored");
    rd_chk(6'h05, 8'h00, "R10 late data ignored");
    rd_chk(6'h02, 8'h02, "R3 kill bit stored");
    wr(6'h00, 8'h10);

    // index wrap
    for (int i = 0; i < DEPTH; i++) wr(6'h07, 8'(i));
    chk(buf_idx == '0, "R12 index wraps", int'(buf_idx), 0);
    wr(6'h07, 8'hC3);
    chk(buf_idx == IW'(1), "R12 index after wrap", int'(buf_idx), 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected requests seen", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule